// File: doc/BRIEF.md
# Pulse Pattern Output Latch

This block drives a 16-bit group of output pins with a bit pattern that moves forward on hardware timer events. It holds the pattern now on the pins in an output-data register and the pattern to come in a next-data register. A transfer engine or software loads the next-data register ahead of time. When the chosen timer compare-match pulse arrives, the next-data bits that are enabled for transfer are copied into the output-data register. The pins then change without any software action at the moment of the event.

The 16 bits form two 8-bit groups. Each group has its own trigger select, so the two halves can step on different timer channels. A direction register decides which bits drive their pins. A bit set as an input drives 0 and shows low on the output-enable vector. All configuration goes through one simple synchronous write port.

Top module: `ppo_latch`

## Requirements
- R1: While rst_ni is low, every register clears, so pin_o and pin_oe_o are 0. After reset, both stay 0 until something is written.
- R2: A write to address 0 (output data) shows on pin_o, for bits whose direction is output, in the cycle after the write. No trigger is needed.
- R3: A write to address 1 (next data) does not change pin_o. Without a selected trigger, the output data holds its value.
- R4: In the cycle after a selected trigger, each bit enabled by address 2 (transfer enable, 1 = take part) takes its next-data value. Each disabled bit keeps its old output value.
- R5: Address 4 (trigger select) picks the compare-match input index for each group. Bits [1:0] select for the group on pin bits [7:0], and bits [3:2] select for the group on bits [15:8]. Pulses on compare-match inputs that are not selected have no effect.
- R6: Address 3 (direction, 1 = output) is copied to pin_oe_o. A bit whose direction is 0 drives 0 on pin_o, even though its output data is kept.
- R7: If a next-data write and a selected trigger fall in the same cycle, the transfer uses the old next-data value. The new value is kept for the following trigger.
- R8: If an output-data write and a selected trigger fall in the same cycle, the written value wins for every bit of the group.
- R9: A trigger selected by one group does not change the other group's output data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register select: 0 output, 1 next, 2 enable, 3 direction, 4 trigger select |
| wr_data_i | input | 16 | Write data |
| cmp_match_i | input | 4 | Timer compare-match pulses, one cycle each |
| pin_o | output | 16 | Pattern output, 0 where the bit is not driven |
| pin_oe_o | output | 16 | 1 where the bit is driven |

## Verification
The hardest case to reach is a register write that lands in the exact cycle a selected compare-match fires. From the ports, that collision is only produced on purpose. The vector table therefore places the write and the compare pulse in one row, once for next data and once for output data. A later trigger-only row then shows whether the new next-data value was kept for the next transfer. A row that hides one group behind direction 0 while a trigger still updates that group checks that the stored data moves even when the pins do not show it.

// File: rtl/ppo_pkg.sv
package ppo_pkg;
  typedef enum logic [2:0] {
    ADDR_OUT  = 3'd0,
    ADDR_NEXT = 3'd1,
    ADDR_EN   = 3'd2,
    ADDR_DIR  = 3'd3,
    ADDR_TSEL = 3'd4
  } reg_addr_e;
endpackage

// File: rtl/ppo_trig_mux.sv
module ppo_trig_mux #(
  parameter int NUM_TRIG = 4,
  localparam int TSW = $clog2(NUM_TRIG)
) (
  input  logic [TSW-1:0]      sel_i,
  input  logic [NUM_TRIG-1:0] cmp_i,
  output logic                trig_o
);
  always_comb begin
    trig_o = 1'b0;
    for (int i = 0; i < NUM_TRIG; i++)
      if (sel_i == TSW'(i)) trig_o = cmp_i[i];
  end
endmodule

// File: rtl/ppo_group.sv
module ppo_group #(
  parameter int GW       = 8,
  parameter int NUM_TRIG = 4,
  localparam int TSW = $clog2(NUM_TRIG)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_out_i,
  input  logic                wr_nxt_i,
  input  logic                wr_en_i,
  input  logic                wr_dir_i,
  input  logic                wr_tsel_i,
  input  logic [GW-1:0]       wdata_i,
  input  logic [TSW-1:0]      tsel_i,
  input  logic [NUM_TRIG-1:0] cmp_i,
  output logic [GW-1:0]       pin_o,
  output logic [GW-1:0]       oe_o
);
  logic [GW-1:0]  out_q, nxt_q, en_q, dir_q;
  logic [TSW-1:0] tsel_q;
  logic           trig;

  ppo_trig_mux #(.NUM_TRIG(NUM_TRIG)) u_mux (
    .sel_i (tsel_q),
    .cmp_i (cmp_i),
    .trig_o(trig)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q  <= '0;
      nxt_q  <= '0;
      en_q   <= '0;
      dir_q  <= '0;
      tsel_q <= '0;
    end else begin
      // software write overrides the trigger transfer
      if (wr_out_i)  out_q <= wdata_i;
      else if (trig) out_q <= (out_q & ~en_q) | (nxt_q & en_q);
      // trigger samples old nxt_q; new value lands afterwards
      if (wr_nxt_i)  nxt_q  <= wdata_i;
      if (wr_en_i)   en_q   <= wdata_i;
      if (wr_dir_i)  dir_q  <= wdata_i;
      if (wr_tsel_i) tsel_q <= tsel_i;
    end
  end

  assign pin_o = out_q & dir_q;
  assign oe_o  = dir_q;

  a_r3_hold_without_trigger: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!trig && !wr_out_i) |=> $stable(out_q));
  a_r4_enabled_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig && !wr_out_i) |=> ((out_q & $past(en_q)) == ($past(nxt_q) & $past(en_q))));
  a_r4_disabled_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig && !wr_out_i) |=> ((out_q & ~$past(en_q)) == ($past(out_q) & ~$past(en_q))));
  a_r7_next_after_transfer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_nxt_i |=> (nxt_q == $past(wdata_i)));
  a_r8_write_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_out_i |=> (out_q == $past(wdata_i)));
endmodule

// File: rtl/ppo_latch.sv
module ppo_latch #(
  parameter int NUM_GROUPS = 2,
  parameter int GW         = 8,
  parameter int NUM_TRIG   = 4,
  localparam int DW  = NUM_GROUPS * GW,
  localparam int TSW = $clog2(NUM_TRIG)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_valid_i,
  input  logic [2:0]          wr_addr_i,
  input  logic [DW-1:0]       wr_data_i,
  input  logic [NUM_TRIG-1:0] cmp_match_i,
  output logic [DW-1:0]       pin_o,
  output logic [DW-1:0]       pin_oe_o
);
  import ppo_pkg::*;

  logic wr_out, wr_nxt, wr_en, wr_dir, wr_tsel;
  assign wr_out  = wr_valid_i && (wr_addr_i == ADDR_OUT);
  assign wr_nxt  = wr_valid_i && (wr_addr_i == ADDR_NEXT);
  assign wr_en   = wr_valid_i && (wr_addr_i == ADDR_EN);
  assign wr_dir  = wr_valid_i && (wr_addr_i == ADDR_DIR);
  assign wr_tsel = wr_valid_i && (wr_addr_i == ADDR_TSEL);

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    ppo_group #(.GW(GW), .NUM_TRIG(NUM_TRIG)) u_grp (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_out_i (wr_out),
      .wr_nxt_i (wr_nxt),
      .wr_en_i  (wr_en),
      .wr_dir_i (wr_dir),
      .wr_tsel_i(wr_tsel),
      .wdata_i  (wr_data_i[g*GW +: GW]),
      .tsel_i   (wr_data_i[g*TSW +: TSW]),
      .cmp_i    (cmp_match_i),
      .pin_o    (pin_o[g*GW +: GW]),
      .oe_o     (pin_oe_o[g*GW +: GW])
    );
  end

  a_r6_undriven_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_o & ~pin_oe_o) == '0);
  a_r1_reset_clear: assert property (@(posedge clk_i)
    !rst_ni |-> (pin_o == '0 && pin_oe_o == '0));
endmodule

// File: tb/ppo_latch_bench.sv
module ppo_latch_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 17;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [3:0]  cmp = '0;
  logic [15:0] pin, oe;
  int          n_chk = 0;
  int          n_err = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ppo_latch u_ppo_latch (
    .clk_i(clk), .rst_ni(rst_n), .wr_valid_i(wr_valid), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .cmp_match_i(cmp), .pin_o(pin), .pin_oe_o(oe)
  );

  // {req, we, addr, data, cmp, exp_pin, exp_oe}
  localparam logic [63:0] VEC [NV] = '{
    {8'd6, 1'b1, 3'd3, 16'hFFFF, 4'h0, 16'h0000, 16'hFFFF}, // R6 dir all out
    {8'd2, 1'b1, 3'd0, 16'h1234, 4'h0, 16'h1234, 16'hFFFF}, // R2 initial value
    {8'd3, 1'b1, 3'd1, 16'hABCD, 4'h0, 16'h1234, 16'hFFFF}, // R3 next hidden
    {8'd3, 1'b1, 3'd2, 16'hFFFF, 4'h0, 16'h1234, 16'hFFFF}, // R3 enable all
    {8'd5, 1'b1, 3'd4, 16'h0009, 4'h0, 16'h1234, 16'hFFFF}, // R5 g0=1 g1=2
    {8'd5, 1'b0, 3'd0, 16'h0000, 4'h1, 16'h1234, 16'hFFFF}, // R5 unselected
    {8'd9, 1'b0, 3'd0, 16'h0000, 4'h2, 16'h12CD, 16'hFFFF}, // R9 group0 only
    {8'd9, 1'b0, 3'd0, 16'h0000, 4'h4, 16'hABCD, 16'hFFFF}, // R9 group1 only
    {8'd4, 1'b1, 3'd2, 16'h0F0F, 4'h0, 16'hABCD, 16'hFFFF}, // R4 partial enable
    {8'd4, 1'b1, 3'd1, 16'h5678, 4'h0, 16'hABCD, 16'hFFFF}, // R4 new next
    {8'd4, 1'b0, 3'd0, 16'h0000, 4'h6, 16'hA6C8, 16'hFFFF}, // R4 masked copy
    {8'd7, 1'b1, 3'd1, 16'hFFFF, 4'h2, 16'hA6C8, 16'hFFFF}, // R7 collision
    {8'd7, 1'b0, 3'd0, 16'h0000, 4'h2, 16'hA6CF, 16'hFFFF}, // R7 kept value
    {8'd6, 1'b1, 3'd3, 16'h00FF, 4'h0, 16'h00CF, 16'h00FF}, // R6 hide high
    {8'd6, 1'b0, 3'd0, 16'h0000, 4'h4, 16'h00CF, 16'h00FF}, // R6 hidden update
    {8'd6, 1'b1, 3'd3, 16'hFFFF, 4'h0, 16'hAFCF, 16'hFFFF}, // R6 revealed
    {8'd8, 1'b1, 3'd0, 16'h0000, 4'h6, 16'h0000, 16'hFFFF}  // R8 write wins
  };

  task automatic check(input string tag, input logic [15:0] ep, input logic [15:0] eo);
    n_chk++;
    if (pin !== ep || oe !== eo) begin
      n_err++;
      $display("FAIL %s pin=%h oe=%h expected pin=%h oe=%h", tag, pin, oe, ep, eo);
    end
  endtask

  initial begin
    #(CLK_PERIOD*2000);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", 16'h0000, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after reset", 16'h0000, 16'h0000);
    for (int i = 0; i < NV; i++) begin
      wr_valid = VEC[i][55];
      wr_addr  = VEC[i][54:52];
      wr_data  = VEC[i][51:36];
      cmp      = VEC[i][35:32];
      @(posedge clk);
      @(negedge clk);
      wr_valid = 1'b0;
      cmp = '0;
      check($sformatf("R%0d vec%0d", VEC[i][63:56], i), VEC[i][31:16], VEC[i][15:0]);
    end
    // R4 disabled bits: zero enable, trigger leaves pattern intact
    wr_valid = 1'b1; wr_addr = 3'd0; wr_data = 16'h5A5A;
    @(posedge clk); @(negedge clk);
    wr_addr = 3'd2; wr_data = 16'h0000;
    @(posedge clk); @(negedge clk);
    wr_valid = 1'b0; cmp = 4'h6;
    @(posedge clk); @(negedge clk);
    cmp = '0;
    check("R4 all disabled", 16'h5A5A, 16'hFFFF);
    // R1 reset mid-run
    rst_n = 1'b0;
    #1;
    check("R1 async reset", 16'h0000, 16'h0000);
    @(negedge clk);
    rst_n = 1'b1;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule